// File: doc/BRIEF.md
# Byte Stack Pointer Unit

This unit keeps an upward-growing byte stack in a small internal data RAM of a microcontroller. An 8-bit stack pointer starts one byte below the second register bank. A push raises the pointer first and then stores the byte at the new address. A pop reads the byte at the current pointer and then lowers the pointer. Bytes therefore come back last-in, first-out.

The RAM is single-port and synchronous, and the unit owns it. A popped byte appears one clock after the request, together with a one-cycle valid strobe. While that read is outstanding the unit reports busy and ignores any new push or pop. Software can write the pointer directly. That load wins over any request in the same cycle and also clears the sticky error flags.

Three sticky flags record error conditions. One marks a push that wrapped the pointer past the top. One marks a pop that wrapped it past the bottom. One marks a cycle in which push and pop were requested together.

Top module: `byte_stack_unit`

## Requirements
- R1: After reset the pointer reads 07h, and the busy output, the valid strobe and all three flags are low.
- R2: An accepted push makes the pointer one higher and writes the input byte at that new address. The first push after reset therefore lands at 08h.
- R3: An accepted pop reads the byte at the current pointer and then lowers the pointer by one. Popped bytes come back in the reverse order of pushing.
- R4: The byte from an accepted pop is on the data output, with the valid strobe high, in the cycle after the pop request and only in that cycle.
- R5: The busy output is high in the cycle after an accepted pop. A push or pop requested while busy is high changes neither the pointer nor the RAM.
- R6: A pointer load takes the load value in the next cycle, even when push or pop is also requested, and it clears all three flags.
- R7: A cycle with push and pop both requested, without a load and while not busy, leaves the pointer and the RAM unchanged and sets the sticky conflict flag.
- R8: A push at pointer FFh wraps the pointer to 00h, writes there, and sets the sticky overflow flag.
- R9: A pop at pointer 00h wraps the pointer to FFh and sets the sticky underflow flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| push_i | input | 1 | Push request |
| pop_i | input | 1 | Pop request |
| push_data_i | input | 8 | Byte to push |
| load_i | input | 1 | Direct pointer load |
| load_val_i | input | 8 | Value for the pointer load |
| pop_data_o | output | 8 | Popped byte |
| pop_valid_o | output | 1 | Popped byte valid strobe |
| busy_o | output | 1 | Read outstanding; push and pop are ignored |
| sp_o | output | 8 | Current stack pointer |
| ovf_o | output | 1 | Sticky overflow flag |
| unf_o | output | 1 | Sticky underflow flag |
| clash_o | output | 1 | Sticky push/pop conflict flag |

## Verification
The assertions are checked on every cycle and cover the pointer rules. These are the step up on a push and the step down on a pop, the hold on a conflict, the priority of a load, the wrap flags, the valid strobe following a pop, and that no request is accepted while busy. Only the bench's scenarios can show that the RAM holds the right bytes. They show the data coming back in reverse order, the first push landing at 08h, and a push ignored during busy leaving nothing behind. They also show that a rejected conflict writes nothing, which later pops make visible.

// File: rtl/byte_stack_pkg.sv
package byte_stack_pkg;
  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_PUSH  = 3'd1,
    OP_POP   = 3'd2,
    OP_LOAD  = 3'd3,
    OP_CLASH = 3'd4
  } stack_op_e;
endpackage

// File: rtl/stack_req_arbiter.sv
module stack_req_arbiter
  import byte_stack_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      push_i,
  input  logic      pop_i,
  input  logic      load_i,
  output stack_op_e op_o,
  output logic      busy_o
);
  logic rd_pend_q;

  always_comb begin
    op_o = OP_IDLE;
    if (load_i)                  op_o = OP_LOAD;
    else if (rd_pend_q)          op_o = OP_IDLE;
    else if (push_i && pop_i)    op_o = OP_CLASH;
    else if (push_i)             op_o = OP_PUSH;
    else if (pop_i)              op_o = OP_POP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_pend_q <= 1'b0;
    else         rd_pend_q <= (op_o == OP_POP);
  end

  assign busy_o = rd_pend_q;

  AST_NO_REQ_WHEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (op_o != OP_PUSH && op_o != OP_POP)); // R5
  AST_BUSY_AFTER_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_o == OP_POP) |=> busy_o); // R5
endmodule

// File: rtl/stack_ptr_reg.sv
module stack_ptr_reg
  import byte_stack_pkg::*;
#(
  parameter int unsigned PTR_W     = 8,
  parameter logic [PTR_W-1:0] RESET_PTR = 8'h07
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  stack_op_e        op_i,
  input  logic [PTR_W-1:0] load_val_i,
  output logic [PTR_W-1:0] sp_o,
  output logic [PTR_W-1:0] sp_inc_o,
  output logic             ovf_o,
  output logic             unf_o,
  output logic             clash_o
);
  localparam logic [PTR_W-1:0] PTR_MAX = {PTR_W{1'b1}};

  logic [PTR_W-1:0] sp_q, sp_dec;
  logic ovf_q, unf_q, clash_q;

  assign sp_inc_o = sp_q + 1'b1;
  assign sp_dec   = sp_q - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q    <= RESET_PTR;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
      clash_q <= 1'b0;
    end else begin
      unique case (op_i)
        OP_LOAD: begin
          sp_q    <= load_val_i;
          ovf_q   <= 1'b0;
          unf_q   <= 1'b0;
          clash_q <= 1'b0;
        end
        OP_PUSH: begin
          sp_q <= sp_inc_o;
          if (sp_q == PTR_MAX) ovf_q <= 1'b1;
        end
        OP_POP: begin
          sp_q <= sp_dec;
          if (sp_q == '0) unf_q <= 1'b1;
        end
        OP_CLASH: clash_q <= 1'b1;
        default: ;
      endcase
    end
  end

  assign sp_o    = sp_q;
  assign ovf_o   = ovf_q;
  assign unf_o   = unf_q;
  assign clash_o = clash_q;

  AST_PUSH_STEP_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_PUSH) |=> sp_o == PTR_W'($past(sp_o) + 1'b1)); // R2
  AST_POP_STEP_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_POP) |=> sp_o == PTR_W'($past(sp_o) - 1'b1)); // R3
  AST_CLASH_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_CLASH) |=> (clash_o && $stable(sp_o))); // R7
  AST_NO_OVERFLOW_MISSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_PUSH && sp_o == PTR_MAX) |=> (ovf_o && sp_o == '0)); // R8
  AST_NO_UNDERFLOW_MISSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_POP && sp_o == '0) |=> (unf_o && sp_o == PTR_MAX)); // R9
endmodule

// File: rtl/stack_ram.sv
module stack_ram #(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
    if (re_i) rdata_q <= mem_q[addr_i];
  end

  assign rdata_o = rdata_q;

  always_comb if (we_i) assert (!re_i); // R7 single port: one access per cycle
endmodule

// File: rtl/byte_stack_unit.sv
module byte_stack_unit
  import byte_stack_pkg::*;
#(
  parameter int unsigned PTR_W     = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned RAM_DEPTH = 256,
  parameter logic [PTR_W-1:0] RESET_PTR = 8'h07
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              load_i,
  input  logic [PTR_W-1:0]  load_val_i,
  output logic [DATA_W-1:0] pop_data_o,
  output logic              pop_valid_o,
  output logic              busy_o,
  output logic [PTR_W-1:0]  sp_o,
  output logic              ovf_o,
  output logic              unf_o,
  output logic              clash_o
);
  localparam int unsigned ADDR_W = $clog2(RAM_DEPTH);

  stack_op_e        op;
  logic [PTR_W-1:0] sp_cur, sp_inc, ram_ptr;
  logic             busy;

  stack_req_arbiter u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push_i),
    .pop_i  (pop_i),
    .load_i (load_i),
    .op_o   (op),
    .busy_o (busy)
  );

  stack_ptr_reg #(.PTR_W(PTR_W), .RESET_PTR(RESET_PTR)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (op),
    .load_val_i (load_val_i),
    .sp_o       (sp_cur),
    .sp_inc_o   (sp_inc),
    .ovf_o      (ovf_o),
    .unf_o      (unf_o),
    .clash_o    (clash_o)
  );

  // pre-increment on push, current pointer on pop
  assign ram_ptr = (op == OP_PUSH) ? sp_inc : sp_cur;

  stack_ram #(.DEPTH(RAM_DEPTH), .DATA_W(DATA_W)) u_ram (
    .clk_i   (clk_i),
    .we_i    (op == OP_PUSH),
    .re_i    (op == OP_POP),
    .addr_i  (ram_ptr[ADDR_W-1:0]),
    .wdata_i (push_data_i),
    .rdata_o (pop_data_o)
  );

  assign pop_valid_o = busy;
  assign busy_o      = busy;
  assign sp_o        = sp_cur;

  AST_VALID_AFTER_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !load_i && !busy_o) |=> pop_valid_o); // R4
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_valid_o |=> !pop_valid_o); // R4
  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (sp_o == $past(load_val_i) && !ovf_o && !unf_o && !clash_o)); // R6
endmodule

// File: tb/byte_stack_unit_tb_top.sv
module byte_stack_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic push_i = 0, pop_i = 0, load_i = 0;
  logic [7:0] push_data_i = 0, load_val_i = 0;
  logic [7:0] pop_data_o, sp_o;
  logic pop_valid_o, busy_o, ovf_o, unf_o, clash_o;

  int n_tests = 0, n_fail = 0;
  bit compare_en = 0, done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_stack_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .push_i(push_i), .pop_i(pop_i),
    .push_data_i(push_data_i), .load_i(load_i), .load_val_i(load_val_i),
    .pop_data_o(pop_data_o), .pop_valid_o(pop_valid_o), .busy_o(busy_o),
    .sp_o(sp_o), .ovf_o(ovf_o), .unf_o(unf_o), .clash_o(clash_o)
  );

  // behavioural reference
  int m_sp, m_busy, m_ovf, m_unf, m_clash, m_data;
  int m_mem [int];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sp = 7; m_busy = 0; m_ovf = 0; m_unf = 0; m_clash = 0; m_data = -1;
    end else begin
      int popped;
      popped = 0;
      if (load_i) begin
        m_sp = load_val_i; m_ovf = 0; m_unf = 0; m_clash = 0;
      end else if (m_busy != 0) begin
      end else if (push_i && pop_i) begin
        m_clash = 1;
      end else if (push_i) begin
        if (m_sp == 255) m_ovf = 1;
        m_sp = (m_sp + 1) % 256;
        m_mem[m_sp] = push_data_i;
      end else if (pop_i) begin
        if (m_sp == 0) m_unf = 1;
        m_data = m_mem.exists(m_sp) ? m_mem[m_sp] : -1;
        m_sp = (m_sp + 255) % 256;
        popped = 1;
      end
      m_busy = popped;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (compare_en) begin
    chk("R2 R3 R6 sp", sp_o, m_sp);
    chk("R5 busy", busy_o, m_busy);
    chk("R4 valid", pop_valid_o, m_busy);
    if (m_busy != 0 && m_data >= 0) chk("R3 R4 pop data", pop_data_o, m_data);
    chk("R8 ovf", ovf_o, m_ovf);
    chk("R9 unf", unf_o, m_unf);
    chk("R7 clash", clash_o, m_clash);
  end

  task automatic drv(input logic pu, input logic po, input logic ld,
                     input logic [7:0] lv, input logic [7:0] d);
    @(negedge clk);
    push_i = pu; pop_i = po; load_i = ld; load_val_i = lv; push_data_i = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 sp reset", sp_o, 8'h07);
    chk("R1 busy reset", busy_o, 0);
    chk("R1 valid reset", pop_valid_o, 0);
    chk("R1 flags reset", {ovf_o, unf_o, clash_o}, 0);
    rst_n = 1'b1;
    compare_en = 1;
    // R2: pushes land at 08h upward
    drv(1, 0, 0, 0, 8'hA1);
    drv(1, 0, 0, 0, 8'hB2);
    drv(1, 0, 0, 0, 8'hC3);
    drv(0, 0, 0, 0, 0);
    chk("R2 sp after three pushes", sp_o, 8'h0A);
    // R3 R5: back-to-back pops, the second is ignored while busy
    drv(0, 1, 0, 0, 0);
    drv(0, 1, 0, 0, 0);
    drv(0, 1, 0, 0, 0);
    drv(0, 0, 0, 0, 0);
    // R5: push during busy ignored
    drv(0, 1, 0, 0, 0);
    drv(1, 0, 0, 0, 8'h5E);
    drv(0, 0, 0, 0, 0);
    chk("R5 push ignored while busy", sp_o, 8'h07);
    // R7: conflict
    drv(1, 1, 0, 0, 8'hEE);
    drv(0, 0, 0, 0, 0);
    chk("R7 clash flag", clash_o, 1);
    // R6: load over push, clears flags
    drv(1, 0, 1, 8'hFE, 8'h11);
    drv(0, 0, 0, 0, 0);
    chk("R6 load priority", sp_o, 8'hFE);
    // R8: wrap on push
    drv(1, 0, 0, 0, 8'h21);
    drv(1, 0, 0, 0, 8'h22);
    drv(0, 0, 0, 0, 0);
    chk("R8 ovf wrap", {ovf_o, sp_o}, {1'b1, 8'h00});
    // R9: wrap on pop, data from 00h
    drv(0, 1, 0, 0, 0);
    drv(0, 0, 0, 0, 0);
    chk("R9 unf wrap", {unf_o, sp_o}, {1'b1, 8'hFF});
    drv(0, 1, 0, 0, 0);
    drv(0, 0, 0, 0, 0);
    drv(0, 0, 1, 8'h30, 0);
    drv(0, 0, 0, 0, 0);
    chk("R6 flags cleared", {ovf_o, unf_o, clash_o}, 0);
    // mixed traffic
    for (int i = 0; i < 400; i++)
      drv($urandom_range(0, 2) == 0, $urandom_range(0, 2) == 0,
          $urandom_range(0, 30) == 0, 8'($urandom), 8'($urandom));
    drv(0, 0, 0, 0, 0);
    drv(0, 0, 0, 0, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule